// File: doc/BRIEF.md
# Write-Once Clock Ratio Selector

This block derives two clock enables from a free-running oscillator clock. The first, the system tick, marks one system-clock period. The second, the instruction tick, marks one machine cycle. Both are single-cycle pulses in the oscillator domain, so the logic that consumes them stays on one clock and avoids glitches. After reset the system tick fires once every 8 oscillator cycles. The instruction tick fires on every fourth system tick.

The processor may change the system ratio exactly once. It has three select strobes, one each for divide by 1, 2 and 4. The first accepted strobe sets a lock, and every later strobe is ignored, including one that asks for the ratio already in force. A requested ratio becomes active at the next system-tick boundary, and the instruction phase counter restarts there.

A wake-from-backup strobe acts at once. It forces the ratio back to divide by 8, restarts both counters and clears the lock, so a later select strobe is accepted again.

Top module: `clk_ratio_lock`

## Requirements
- R1: After reset, ratioCode is 2'b00 (divide by 8), sysTick pulses every 8 clk cycles and instTick pulses every 32 clk cycles.
- R2: An accepted divide-by-1 select gives ratioCode 2'b01, sysTick in every cycle and instTick every 4 cycles.
- R3: An accepted divide-by-2 select gives ratioCode 2'b10, sysTick every 2 cycles and instTick every 8 cycles.
- R4: An accepted divide-by-4 select gives ratioCode 2'b11, sysTick every 4 cycles and instTick every 16 cycles.
- R5: Once a select has been accepted, any later select strobe, for any ratio, leaves ratioCode and both tick periods unchanged.
- R6: In the cycle after backupWake is high, ratioCode reads 2'b00 and the divide-by-8 periods resume. A select strobe issued after the wake is accepted.
- R7: instTick is high only in a cycle where sysTick is high, and it fires on every fourth sysTick.
- R8: If several select strobes are high in one unlocked cycle, divide by 1 wins over divide by 2, which wins over divide by 4, and the lock is set.
- R9: Apart from a wake, ratioCode changes only on the clock edge that ends a cycle in which sysTick was high.
- R10: If backupWake and a select strobe are high in the same cycle, the wake wins: the ratio is divide by 8 and the lock stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| selDiv1 | input | 1 | Strobe requesting system ratio 1 |
| selDiv2 | input | 1 | Strobe requesting system ratio 2 |
| selDiv4 | input | 1 | Strobe requesting system ratio 4 |
| backupWake | input | 1 | Strobe for return from backup: restore divide by 8 and unlock |
| sysTick | output | 1 | One-cycle system clock enable |
| instTick | output | 1 | One-cycle instruction (machine cycle) enable |
| ratioCode | output | 2 | Active ratio: 00 div8, 01 div1, 10 div2, 11 div4 |

## Verification
Each of the four ratios is measured on both tick outputs and on ratioCode, so that a wrong divider limit can be told apart from a wrong instruction phase. Repeated selects, both for the same ratio and for a different one, separate a missing lock from a lock that only compares ratios. Wake sequences check that the lock is cleared: a wake alone, then a select, and then a wake raised together with a select. A strobe for all three ratios at once tests the priority order.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_DIV8 = 2'b00,
    RATIO_DIV1 = 2'b01,
    RATIO_DIV2 = 2'b10,
    RATIO_DIV4 = 2'b11
  } ratio_e;

  typedef struct packed {
    logic   restore;
    ratio_e target;
  } ctrl_strobe_t;

endpackage

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         selDiv1,
  input  logic         selDiv2,
  input  logic         selDiv4,
  input  logic         backupWake,
  output ctrl_strobe_t ctlOut
);

  logic   lockSet;
  ratio_e pendingRatio;
  logic   anySel;
  ratio_e reqRatio;

  assign anySel = selDiv1 | selDiv2 | selDiv4;

  always_comb begin
    if (selDiv1)      reqRatio = RATIO_DIV1;
    else if (selDiv2) reqRatio = RATIO_DIV2;
    else              reqRatio = RATIO_DIV4;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockSet      <= 1'b0;
      pendingRatio <= RATIO_DIV8;
    end else if (backupWake) begin
      lockSet      <= 1'b0;
      pendingRatio <= RATIO_DIV8;
    end else if (anySel && !lockSet) begin
      lockSet      <= 1'b1;
      pendingRatio <= reqRatio;
    end
  end

  assign ctlOut.restore = backupWake;
  assign ctlOut.target  = pendingRatio;

  // R5: a set lock freezes the requested ratio until a wake
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockSet && !backupWake) |=> ($stable(pendingRatio) && lockSet));

  // R6 / R10: a wake clears the lock and requests divide by 8
  p_wake_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    backupWake |=> (!lockSet && pendingRatio == RATIO_DIV8));

  // R8: divide by 1 wins whenever it is accepted
  p_prio_div1_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selDiv1 && !lockSet && !backupWake) |=> (pendingRatio == RATIO_DIV1));

  // R8: divide by 2 beats divide by 4
  p_prio_div2_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selDiv2 && !selDiv1 && !lockSet && !backupWake) |=> (pendingRatio == RATIO_DIV2));

endmodule

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
#(
  parameter int RESET_DIV = 8,
  parameter int INST_DIV  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t ctlIn,
  output logic         sysTick,
  output logic         instTick,
  output ratio_e       activeRatio
);

  localparam int SW = (RESET_DIV > 1) ? $clog2(RESET_DIV) : 1;
  localparam int IW = (INST_DIV > 1) ? $clog2(INST_DIV) : 1;
  localparam logic [SW-1:0] LIM_DIV8 = SW'(RESET_DIV - 1);
  localparam logic [SW-1:0] LIM_DIV1 = SW'(0);
  localparam logic [SW-1:0] LIM_DIV2 = SW'(1);
  localparam logic [SW-1:0] LIM_DIV4 = SW'(3);
  localparam logic [IW-1:0] INST_LAST = IW'(INST_DIV - 1);

  logic [SW-1:0] sysCnt;
  logic [SW-1:0] sysLim;
  logic [IW-1:0] instCnt;
  logic          restoreNow;
  logic          applyNew;

  assign restoreNow = ctlIn.restore;

  always_comb begin
    unique case (activeRatio)
      RATIO_DIV1: sysLim = LIM_DIV1;
      RATIO_DIV2: sysLim = LIM_DIV2;
      RATIO_DIV4: sysLim = LIM_DIV4;
      default:    sysLim = LIM_DIV8;
    endcase
  end

  assign sysTick  = (sysCnt == sysLim);
  assign instTick = sysTick && (instCnt == INST_LAST);
  assign applyNew = (ctlIn.target != activeRatio);

  always_ff @(posedge clk) begin
    if (!rstN || restoreNow) begin
      activeRatio <= RATIO_DIV8;
      sysCnt      <= '0;
      instCnt     <= '0;
    end else if (sysTick) begin
      sysCnt <= '0;
      if (applyNew) begin
        activeRatio <= ctlIn.target;
        instCnt     <= '0;
      end else begin
        instCnt <= (instCnt == INST_LAST) ? '0 : instCnt + 1'b1;
      end
    end else begin
      sysCnt <= sysCnt + 1'b1;
    end
  end

  // R7: the instruction enable only rides on a system enable
  p_inst_on_sys_r7: assert property (@(posedge clk) disable iff (!rstN)
    instTick |-> sysTick);

  // R9: ratio moves only at a system boundary or on a wake
  p_ratio_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeRatio) |-> ($past(sysTick) || $past(restoreNow)));

  // R2: divide by 1 produces a system enable in every cycle
  p_div1_every_r2: assert property (@(posedge clk) disable iff (!rstN)
    (activeRatio == RATIO_DIV1) |-> sysTick);

  // R6: a wake leaves divide by 8 in force on the next cycle
  p_wake_div8_r6: assert property (@(posedge clk) disable iff (!rstN)
    restoreNow |=> (activeRatio == RATIO_DIV8));

endmodule

// File: rtl/clk_ratio_lock.sv
module clk_ratio_lock
  import clk_ratio_pkg::*;
#(
  parameter int RESET_DIV = 8,
  parameter int INST_DIV  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       selDiv1,
  input  logic       selDiv2,
  input  logic       selDiv4,
  input  logic       backupWake,
  output logic       sysTick,
  output logic       instTick,
  output logic [1:0] ratioCode
);

  ctrl_strobe_t ctlBus;
  ratio_e       activeRatio;

  clk_ratio_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selDiv1    (selDiv1),
    .selDiv2    (selDiv2),
    .selDiv4    (selDiv4),
    .backupWake (backupWake),
    .ctlOut     (ctlBus)
  );

  clk_ratio_dp #(
    .RESET_DIV (RESET_DIV),
    .INST_DIV  (INST_DIV)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctlIn       (ctlBus),
    .sysTick     (sysTick),
    .instTick    (instTick),
    .activeRatio (activeRatio)
  );

  assign ratioCode = activeRatio;

endmodule

// File: tb/clk_ratio_lock_tb.sv
module clk_ratio_lock_tb;

  typedef struct {
    logic [1:0] code;
    int         sysPer;
    int         instPer;
    string      tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selDiv1 = 1'b0, selDiv2 = 1'b0, selDiv4 = 1'b0, backupWake = 1'b0;
  logic sysTick, instTick;
  logic [1:0] ratioCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  exp_item_t expQ[$];

  always #4 clk = ~clk;

  clk_ratio_lock u_dut (
    .clk(clk), .rstN(rstN), .selDiv1(selDiv1), .selDiv2(selDiv2),
    .selDiv4(selDiv4), .backupWake(backupWake),
    .sysTick(sysTick), .instTick(instTick), .ratioCode(ratioCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic s1, input logic s2, input logic s4, input logic wk);
    @(negedge clk);
    selDiv1 = s1; selDiv2 = s2; selDiv4 = s4; backupWake = wk;
    @(negedge clk);
    selDiv1 = 1'b0; selDiv2 = 1'b0; selDiv4 = 1'b0; backupWake = 1'b0;
  endtask

  task automatic expectRatio(input logic [1:0] code, input int sp, input int ip,
                             input string tag);
    exp_item_t it;
    repeat (40) @(negedge clk);
    it.code = code; it.sysPer = sp; it.instPer = ip; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  // Monitor: measure periods and compare against the queued expectation
  initial begin
    forever begin
      exp_item_t it;
      int cnt;
      wait (expQ.size() > 0);
      it = expQ[0];
      do @(negedge clk); while (!sysTick);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!sysTick);
      check({it.tag, " sysTick period"}, cnt, it.sysPer);
      do @(negedge clk); while (!instTick);
      check({it.tag, " R7 sysTick with instTick"}, int'(sysTick), 1);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!instTick);
      check({it.tag, " instTick period"}, cnt, it.instPer);
      check({it.tag, " ratioCode"}, int'(ratioCode), int'(it.code));
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset ratioCode", int'(ratioCode), 0);
    expectRatio(2'b00, 8, 32, "R1 reset");

    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    expectRatio(2'b10, 2, 8, "R3 div2");

    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    expectRatio(2'b10, 2, 8, "R5 later div1 ignored");
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    expectRatio(2'b10, 2, 8, "R5 repeat div2 ignored");

    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 ratioCode after wake", int'(ratioCode), 0);
    expectRatio(2'b00, 8, 32, "R6 wake div8");

    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    expectRatio(2'b11, 4, 16, "R4 div4 after unlock R6");

    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b1, 1'b1, 1'b0);
    expectRatio(2'b01, 1, 4, "R8 R2 all strobes div1");
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    expectRatio(2'b01, 1, 4, "R5 div4 ignored at div1");

    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b1, 1'b0);
    expectRatio(2'b10, 2, 8, "R8 div2 beats div4");

    pulse(1'b0, 1'b1, 1'b0, 1'b1);
    check("R10 wake with select ratioCode", int'(ratioCode), 0);
    expectRatio(2'b00, 8, 32, "R10 wake wins");
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    expectRatio(2'b11, 4, 16, "R10 lock stayed clear");

    // R9: a select raised just after a boundary waits for the next one
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    do @(negedge clk); while (!sysTick);
    @(negedge clk);
    selDiv1 = 1'b1;
    @(negedge clk);
    selDiv1 = 1'b0;
    check("R9 no change before boundary", int'(ratioCode), 0);
    repeat (5) @(negedge clk);
    check("R9 still div8 mid period", int'(ratioCode), 0);
    expectRatio(2'b01, 1, 4, "R9 applied at boundary R2");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule